// File: doc/BRIEF.md
# Cache Bank Capacity Reconfiguration Controller

This controller manages one bank of a shared cache that can be backed by an extra, slower storage layer stacked above it. During a fixed-length epoch it counts two kinds of event: every access to the bank, as a measure of how heavily the bank is used, and every miss. When the epoch closes, it compares both counts against four programmable thresholds: a low and a high threshold for accesses, and a low and a high threshold for misses. It then decides whether the extra layer should be switched on, switched off, or left as it is.

A change of configuration is not free. Every time the enable state flips, the controller raises a stall request to all cores for a fixed number of cycles. When that window ends, it emits a one-cycle completion pulse. The lines held in the fast ways stay in place, so no flush is requested. A strap input marks the bank as shared. A shared bank keeps its extra capacity on at all times and never takes part in the policy.

Top module: `cap_reconfig_ctrl`

## Requirements
- R1: After reset, `cap_enable`, `stall_req` and `reconfig_done` are all 0.
- R2: Epoch boundaries fall on every `INTERVAL_CYCLES`-th rising clock edge after reset is released. The internal enable state changes only on a boundary edge.
- R3: At a boundary, a disabled bank becomes enabled when both the access count is at least `use_hi_thr` and the miss count is at least `miss_hi_thr`.
- R4: At a boundary, an enabled bank becomes disabled when the access count is below `use_lo_thr` and the miss count is below `miss_lo_thr`, unless the condition in R3 also holds.
- R5: Any other combination at a boundary, such as many accesses with few misses, leaves the enable state unchanged.
- R6: A change of enable state raises `stall_req` for exactly `STALL_CYCLES` cycles, starting in the cycle that follows the boundary edge. No change is made at a boundary while a stall is still running.
- R7: `reconfig_done` is high for exactly one cycle: the first cycle after `stall_req` falls.
- R8: While `shared_bank` is 1, `cap_enable` is 1, no stall is raised, and the underlying enable state is frozen.
- R9: The access and miss counts saturate at 2^`CNT_W`-1 instead of wrapping.
- R10: Each count restarts at the boundary edge. A strobe present in the boundary cycle counts toward the next epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_strobe | input | 1 | One bank access in this cycle |
| miss_strobe | input | 1 | One bank miss in this cycle |
| use_lo_thr | input | CNT_W | Access count below this value is low usage |
| use_hi_thr | input | CNT_W | Access count at or above this value is high usage |
| miss_lo_thr | input | CNT_W | Miss count below this value is a low miss rate |
| miss_hi_thr | input | CNT_W | Miss count at or above this value is a high miss rate |
| shared_bank | input | 1 | Strap: the bank holds shared data, so capacity is fixed on |
| cap_enable | output | 1 | Extra storage layer enabled |
| stall_req | output | 1 | Stall request to all cores |
| reconfig_done | output | 1 | One-cycle pulse when the stall window ends |

## Verification
The enable state is registered on the boundary edge, so a new `cap_enable` value can be seen one half-cycle later, at the following falling edge. `stall_req` is high from that same point for `STALL_CYCLES` cycles, and `reconfig_done` follows one cycle after the final stall cycle. The bench drives strobes on falling edges and advances a reference model of its own on each rising edge. It compares all three outputs at the next falling edge, so every check lands in the cycle where the result is due. Directed epochs (saturated counts, mixed metrics, silent epochs, a shared bank) sit alongside random-density epochs with a fixed seed.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

  typedef enum logic [1:0] {
    VOTE_HOLD   = 2'd0,
    VOTE_GROW   = 2'd1,
    VOTE_SHRINK = 2'd2
  } vote_e;

  // Policy verdict for one epoch; growth wins if both conditions hold.
  function automatic vote_e judge(input logic [31:0] acc,
                                  input logic [31:0] miss,
                                  input logic [31:0] use_lo,
                                  input logic [31:0] use_hi,
                                  input logic [31:0] miss_lo,
                                  input logic [31:0] miss_hi);
    if (acc >= use_hi && miss >= miss_hi)
      return VOTE_GROW;
    else if (acc < use_lo && miss < miss_lo)
      return VOTE_SHRINK;
    else
      return VOTE_HOLD;
  endfunction

  // Saturating increment.
  function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                           input logic        hit,
                                           input logic [31:0] top);
    if (hit && cur != top)
      return cur + 32'd1;
    else
      return cur;
  endfunction

endpackage

// File: rtl/rcfg_epoch_timer.sv
module rcfg_epoch_timer #(
  parameter int INTERVAL_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic epoch_end
);
  localparam int PW = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(INTERVAL_CYCLES - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)         phase <= '0;
    else if (epoch_end) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  assign epoch_end = (phase == LAST);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_end |=> (phase == '0)); // R2

endmodule

// File: rtl/rcfg_evt_counter.sv
module rcfg_evt_counter
  import rcfg_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (clear)
      count <= CNT_W'(hit);
    else
      count <= CNT_W'(sat_step(32'(count), hit, 32'(CNT_MAX)));
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clear) |=> (count == CNT_MAX)); // R9
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count < 2)); // R10

endmodule

// File: rtl/rcfg_policy.sv
module rcfg_policy
  import rcfg_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int STALL_CYCLES = 100_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             epoch_end,
  input  logic             shared_bank,
  input  logic [CNT_W-1:0] acc_cnt,
  input  logic [CNT_W-1:0] miss_cnt,
  input  logic [CNT_W-1:0] use_lo_thr,
  input  logic [CNT_W-1:0] use_hi_thr,
  input  logic [CNT_W-1:0] miss_lo_thr,
  input  logic [CNT_W-1:0] miss_hi_thr,
  output logic             en_state,
  output logic             stall_active,
  output logic             done_pulse
);
  localparam int SW = $clog2(STALL_CYCLES + 1);
  localparam logic [SW-1:0] STALL_LOAD = SW'(STALL_CYCLES);

  logic [SW-1:0] stall_cnt;
  vote_e         vote;
  logic          want_flip;

  assign vote = judge(32'(acc_cnt), 32'(miss_cnt), 32'(use_lo_thr),
                      32'(use_hi_thr), 32'(miss_lo_thr), 32'(miss_hi_thr));

  assign want_flip = epoch_end && !shared_bank && !stall_active &&
                     ((vote == VOTE_GROW && !en_state) ||
                      (vote == VOTE_SHRINK && en_state));

  assign stall_active = (stall_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_state   <= 1'b0;
      stall_cnt  <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= (stall_cnt == SW'(1));
      if (want_flip) begin
        en_state  <= !en_state;
        stall_cnt <= STALL_LOAD;
      end else if (stall_active) begin
        stall_cnt <= stall_cnt - 1'b1;
      end
    end
  end

  AST_FLIP_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_state != $past(en_state)) |-> $past(epoch_end)); // R2
  AST_FLIP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_state != $past(en_state)) |-> stall_active); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stall_active) |-> $stable(en_state)); // R6
  AST_DONE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(stall_active) && !stall_active)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R7
  AST_SHARED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shared_bank) |-> $stable(en_state)); // R8

endmodule

// File: rtl/cap_reconfig_ctrl.sv
module cap_reconfig_ctrl #(
  parameter int INTERVAL_CYCLES = 10_000_000,
  parameter int STALL_CYCLES    = 100_000,
  parameter int CNT_W           = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_strobe,
  input  logic             miss_strobe,
  input  logic [CNT_W-1:0] use_lo_thr,
  input  logic [CNT_W-1:0] use_hi_thr,
  input  logic [CNT_W-1:0] miss_lo_thr,
  input  logic [CNT_W-1:0] miss_hi_thr,
  input  logic             shared_bank,
  output logic             cap_enable,
  output logic             stall_req,
  output logic             reconfig_done
);
  localparam int N_EVT = 2; // index 0: accesses, 1: misses

  logic             epoch_end;
  logic             en_state;
  logic [N_EVT-1:0] evt_hit;
  logic [CNT_W-1:0] evt_cnt [N_EVT];

  assign evt_hit = {miss_strobe, acc_strobe};

  rcfg_epoch_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .epoch_end (epoch_end)
  );

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    rcfg_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (evt_hit[g]),
      .clear (epoch_end),
      .count (evt_cnt[g])
    );
  end

  rcfg_policy #(.CNT_W(CNT_W), .STALL_CYCLES(STALL_CYCLES)) u_policy (
    .clk          (clk),
    .rst_n        (rst_n),
    .epoch_end    (epoch_end),
    .shared_bank  (shared_bank),
    .acc_cnt      (evt_cnt[0]),
    .miss_cnt     (evt_cnt[1]),
    .use_lo_thr   (use_lo_thr),
    .use_hi_thr   (use_hi_thr),
    .miss_lo_thr  (miss_lo_thr),
    .miss_hi_thr  (miss_hi_thr),
    .en_state     (en_state),
    .stall_active (stall_req),
    .done_pulse   (reconfig_done)
  );

  assign cap_enable = en_state | shared_bank;

  AST_SHARED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_bank && !stall_req) |=> !$rose(stall_req)); // R8

endmodule

// File: tb/cap_reconfig_ctrl_tb.sv
module cap_reconfig_ctrl_tb;
  localparam int IVL = 80;
  localparam int STL = 12;
  localparam int CW  = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_strobe = 1'b0, miss_strobe = 1'b0, shared_bank = 1'b0;
  logic [CW-1:0] use_lo_thr = 6'd10, use_hi_thr = 6'd40;
  logic [CW-1:0] miss_lo_thr = 6'd5, miss_hi_thr = 6'd20;
  logic cap_enable, stall_req, reconfig_done;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int m_phase = 0, m_acc = 0, m_miss = 0, m_stall = 0;
  bit m_en = 0, m_done = 0;

  always #5 clk = ~clk;

  cap_reconfig_ctrl #(.INTERVAL_CYCLES(IVL), .STALL_CYCLES(STL), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .miss_strobe(miss_strobe),
    .use_lo_thr(use_lo_thr), .use_hi_thr(use_hi_thr),
    .miss_lo_thr(miss_lo_thr), .miss_hi_thr(miss_hi_thr),
    .shared_bank(shared_bank), .cap_enable(cap_enable),
    .stall_req(stall_req), .reconfig_done(reconfig_done)
  );

  function automatic bit next_enable(bit en, int a, int m);
    bit grow, shrink;
    grow   = (a >= int'(use_hi_thr)) && (m >= int'(miss_hi_thr));
    shrink = !grow && (a < int'(use_lo_thr)) && (m < int'(miss_lo_thr));
    return en ? !shrink : grow;
  endfunction

  function automatic int bump(int v, bit s);
    return (s && v < CMAX) ? v + 1 : v;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0b exp %0b (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit a, bit m);
    bit nxt;
    acc_strobe  = a;
    miss_strobe = m;
    @(posedge clk);
    m_done = (m_stall == 1);
    if (m_stall > 0) m_stall--;
    if (m_phase == IVL - 1) begin
      if (!shared_bank && m_stall == 0 && !(m_done == 0 && 0)) begin
        nxt = next_enable(m_en, m_acc, m_miss);
        if (nxt != m_en && !(m_stall > 0)) begin
          m_en = nxt;
          m_stall = STL;
        end
      end
      m_acc = a; m_miss = m;
      m_phase = 0;
    end else begin
      m_acc = bump(m_acc, a); m_miss = bump(m_miss, m);
      m_phase++;
    end
    @(negedge clk);
    chk("R2 R3 R4 R5 cap_enable", cap_enable, m_en | shared_bank);
    chk("R6 stall_req", stall_req, m_stall > 0);
    chk("R7 reconfig_done", reconfig_done, m_done);
  endtask

  task automatic run_epoch(int acc_pct, int miss_pct);
    for (int i = 0; i < IVL; i++)
      step($urandom_range(0, 99) < acc_pct, $urandom_range(0, 99) < miss_pct);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired got %0d exp <20000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 cap_enable", cap_enable, 1'b0);
    chk("R1 stall_req", stall_req, 1'b0);
    chk("R1 reconfig_done", reconfig_done, 1'b0);
    rst_n = 1'b1;

    // R3 R9: every cycle strobed, counts saturate high -> enable
    run_epoch(100, 100);
    chk("R3 enabled after busy epoch", cap_enable, 1'b1);
    chk("R6 stall raised", stall_req, 1'b1);
    // R5: many accesses, no misses -> hold
    run_epoch(100, 0);
    chk("R5 mixed epoch holds enable", cap_enable, 1'b1);
    chk("R5 no stall on hold", stall_req, 1'b0);
    // R4 R10: quiet epoch after busy one -> counts restarted -> disable
    run_epoch(0, 0);
    chk("R4 R10 quiet epoch disables", cap_enable, 1'b0);
    chk("R6 stall on disable", stall_req, 1'b1);
    for (int i = 0; i < STL; i++) step(0, 0);
    chk("R7 done pulse after stall", reconfig_done, 1'b1);
    step(0, 0);
    chk("R7 done one cycle only", reconfig_done, 1'b0);
    // R9: high thresholds at the count ceiling need saturation
    for (int i = 0; i < IVL - STL - 1; i++) step(0, 0);
    use_hi_thr = 6'(CMAX); miss_hi_thr = 6'(CMAX);
    run_epoch(100, 100);
    chk("R9 saturated counts reach ceiling", cap_enable, 1'b1);
    use_hi_thr = 6'd40; miss_hi_thr = 6'd20;
    run_epoch(0, 0);
    chk("R4 disable again", cap_enable, 1'b0);
    // R8: shared strap forces enable and freezes the policy
    shared_bank = 1'b1;
    run_epoch(100, 100);
    chk("R8 shared forces enable", cap_enable, 1'b1);
    chk("R8 shared never stalls", stall_req, 1'b0);
    run_epoch(0, 0);
    shared_bank = 1'b0;
    step(0, 0);
    chk("R8 state frozen while shared", cap_enable, 1'b0);
    for (int i = 0; i < IVL - 1; i++) step(0, 0);
    // random-density epochs
    for (int e = 0; e < 12; e++) begin
      if (e == 6) begin
        use_lo_thr = 6'($urandom_range(5, 30));
        use_hi_thr = 6'($urandom_range(30, 63));
        miss_lo_thr = 6'($urandom_range(2, 20));
        miss_hi_thr = 6'($urandom_range(20, 63));
      end
      run_epoch($urandom_range(0, 100), $urandom_range(0, 100));
    end
    finish_run();
  end
endmodule